// File: doc/BRIEF.md
# Byte-Addressed Data Space with Pointer Windows

This block owns a 256-location, byte-wide data address space for a small processor core. The low part holds special-register locations and a reserved gap. The upper part, from 0x60 to 0xFF, is general-purpose RAM held inside the block. Two of the low addresses are windows with no storage of their own. An access to a window is redirected to the location named by that window's 8-bit pointer register. The two pointers also live in the space. Special registers other than the pointers are not kept here. Their locations are forwarded to an external tap, which includes the accumulator at 0x05.

The core issues one access per cycle on a single port. The operation is read, write, bit set or bit clear. Bit set and bit clear are read-modify-write steps done in the same cycle, and they work on every kind of location. A bit operation on a tap location reads the tap and writes back the modified byte in that one cycle. Read data is registered and appears in the cycle after the request. It then holds until the next read.

The map is fixed as follows:
- 0x00 is the window served by pointer 0, which sits at 0x01.
- 0x02 is the window served by pointer 1, which sits at 0x03.
- Tap locations come from a parameter bit map.
- Every other address below 0x60 is reserved.

Top module: `dmem_space`

## Requirements
- R1: After reset both pointers (0x01, 0x03) read 0x00 and rdata_o is 0x00; RAM contents are left undefined.
- R2: A write to an address in 0x60–0xFF stores the byte, and a later read of that address returns it in the cycle after the read request.
- R3: Addresses below 0x60 that are neither a window, a pointer nor a tap location are reserved. They read 0x00, and writes or bit operations to them change nothing and raise no tap write strobe.
- R4: An access to 0x00 acts on the location held in pointer 0, and an access to 0x02 acts on the location held in pointer 1. A pointer may name another pointer.
- R5: When the redirected address is itself a window (0x00 or 0x02), a read returns 0x00 and a write or bit operation changes nothing.
- R6: Accesses to tap locations are forwarded in the request cycle. tap_sel_o is high and tap_addr_o carries the address. A write raises tap_we_o with the byte on tap_wdata_o. A read returns tap_rdata_i. The accumulator is tap location 0x05.
- R7: Op code 2 sets and op code 3 clears bit bit_i (0 is the LSB) of a RAM byte and leaves its other bits unchanged. Op code 0 is read and op code 1 is write.
- R8: Bit set and bit clear also apply to the pointers and to tap locations. A tap location is handled as one cycle that reads it and writes back the modified byte.
- R9: A bit operation through a window applies to the redirected location, under the same rules as R4 and R5.
- R10: rdata_o changes only in the cycle after a read request and holds through writes, bit operations and idle cycles.
- R11: A pointer write takes effect for the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Access request this cycle |
| op_i | input | 2 | 0 read, 1 write, 2 bit set, 3 bit clear |
| addr_i | input | 8 | Direct address |
| wdata_i | input | 8 | Write byte |
| bit_i | input | 3 | Bit index for set/clear |
| rdata_o | output | 8 | Registered read byte |
| tap_sel_o | output | 1 | Access targets a tap location |
| tap_we_o | output | 1 | Tap write strobe |
| tap_addr_o | output | 8 | Resolved address toward the tap |
| tap_wdata_o | output | 8 | Byte written to the tap |
| tap_rdata_i | input | 8 | Tap byte at tap_addr_o, combinational |

## Verification
The assertions check several rules on every cycle:
- The tap write strobe only ever names a tap location.
- At most one storage element is written per cycle.
- Reads that resolve to a reserved or null target return zero.
- The read register and the pointers hold whenever they are not addressed.
- The pointers come out of reset at zero.

Only the bench scenarios can show the values themselves. These cover correct redirection through each window, including a pointer naming a pointer, and the bit patterns left by set and clear. They also show that ignored writes really left the pointers and the tap untouched, and that a freshly written pointer steers the very next access.

// File: rtl/dmem_pkg.sv
`timescale 1ns/1ps
package dmem_pkg;

    typedef enum logic [2:0] {
        CLS_NULL,
        CLS_PTR0,
        CLS_PTR1,
        CLS_TAP,
        CLS_RSVD,
        CLS_RAM
    } loc_class_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_BSET  = 2'd2,
        OP_BCLR  = 2'd3
    } acc_op_e;

    // Tap locations below the RAM base: 04-07, 0A-0B, 0D-0E, 12-1B
    localparam logic [95:0] DEFAULT_TAP_MAP = 96'h0FFC_6CF0;

endpackage

// File: rtl/dmem_decode.sv
`timescale 1ns/1ps
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int RAM_BASE  = 96,
    parameter int WIN0_ADDR = 0,
    parameter int PTR0_ADDR = 1,
    parameter int WIN1_ADDR = 2,
    parameter int PTR1_ADDR = 3,
    parameter logic [RAM_BASE-1:0] TAP_MAP = DEFAULT_TAP_MAP[RAM_BASE-1:0]
) (
    input  logic [WORD_W-1:0] addr_i,
    input  logic [WORD_W-1:0] ptr0_i,
    input  logic [WORD_W-1:0] ptr1_i,
    output logic [WORD_W-1:0] eff_addr_o,
    output loc_class_e        cls_o
);

    localparam int TAP_IDX_W = $clog2(RAM_BASE);
    localparam logic [WORD_W-1:0] W0 = WORD_W'(WIN0_ADDR);
    localparam logic [WORD_W-1:0] W1 = WORD_W'(WIN1_ADDR);
    localparam logic [WORD_W-1:0] P0 = WORD_W'(PTR0_ADDR);
    localparam logic [WORD_W-1:0] P1 = WORD_W'(PTR1_ADDR);
    localparam logic [WORD_W-1:0] RB = WORD_W'(RAM_BASE);

    logic [WORD_W-1:0] eff_d;

    always_comb begin
        if (addr_i == W0) begin
            eff_d = ptr0_i;
        end else if (addr_i == W1) begin
            eff_d = ptr1_i;
        end else begin
            eff_d = addr_i;
        end
    end

    always_comb begin
        if (eff_d == W0 || eff_d == W1) begin
            cls_o = CLS_NULL;
        end else if (eff_d == P0) begin
            cls_o = CLS_PTR0;
        end else if (eff_d == P1) begin
            cls_o = CLS_PTR1;
        end else if (eff_d >= RB) begin
            cls_o = CLS_RAM;
        end else if (TAP_MAP[eff_d[TAP_IDX_W-1:0]]) begin
            cls_o = CLS_TAP;
        end else begin
            cls_o = CLS_RSVD;
        end
    end

    assign eff_addr_o = eff_d;

endmodule

// File: rtl/dmem_ptr_regs.sv
`timescale 1ns/1ps
module dmem_ptr_regs #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we0_i,
    input  logic              we1_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] ptr0_o,
    output logic [WORD_W-1:0] ptr1_o
);

    typedef struct packed {
        logic [WORD_W-1:0] ptr0;
        logic [WORD_W-1:0] ptr1;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we0_i) begin
            st_d.ptr0 = wdata_i;
        end
        if (we1_i) begin
            st_d.ptr1 = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr0_o = st_q.ptr0;
    assign ptr1_o = st_q.ptr1;

    // R11: a pointer not written keeps its value
    assert_ptr0_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we0_i |=> $stable(ptr0_o));
    assert_ptr1_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we1_i |=> $stable(ptr1_o));
    // R1: pointers leave reset at zero
    assert_ptr_reset_R1: assert property (@(posedge clk)
        ($past(!rst_n) && rst_n) |-> (ptr0_o == '0 && ptr1_o == '0));

endmodule

// File: rtl/dmem_gp_ram.sv
`timescale 1ns/1ps
module dmem_gp_ram #(
    parameter int WORD_W   = 8,
    parameter int RAM_BASE = 96
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [WORD_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int SPACE     = 2 ** WORD_W;
    localparam int RAM_WORDS = SPACE - RAM_BASE;
    localparam int IDX_W     = $clog2(RAM_WORDS);

    logic [WORD_W-1:0] mem_d [RAM_WORDS];
    logic [WORD_W-1:0] mem_q [RAM_WORDS];
    logic [WORD_W-1:0] offset;
    logic [IDX_W-1:0]  idx;

    assign offset = addr_i - WORD_W'(RAM_BASE);
    assign idx    = offset[IDX_W-1:0];

    always_comb begin
        for (int w = 0; w < RAM_WORDS; w++) begin
            mem_d[w] = mem_q[w];
        end
        if (we_i && (32'(idx) < RAM_WORDS)) begin
            mem_d[idx] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < RAM_WORDS; w++) begin
            mem_q[w] <= mem_d[w];
        end
    end

    assign rdata_o = (32'(idx) < RAM_WORDS) ? mem_q[idx] : '0;

endmodule

// File: rtl/dmem_space.sv
`timescale 1ns/1ps
module dmem_space
    import dmem_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int RAM_BASE  = 96,
    parameter int WIN0_ADDR = 0,
    parameter int PTR0_ADDR = 1,
    parameter int WIN1_ADDR = 2,
    parameter int PTR1_ADDR = 3,
    parameter logic [RAM_BASE-1:0] TAP_MAP = DEFAULT_TAP_MAP[RAM_BASE-1:0],
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        op_i,
    input  logic [WORD_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [BIT_W-1:0]  bit_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              tap_sel_o,
    output logic              tap_we_o,
    output logic [WORD_W-1:0] tap_addr_o,
    output logic [WORD_W-1:0] tap_wdata_o,
    input  logic [WORD_W-1:0] tap_rdata_i
);

    localparam int TAP_IDX_W = $clog2(RAM_BASE);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t        st_d, st_q;
    acc_op_e           op;
    loc_class_e        cls;
    logic [WORD_W-1:0] eff_addr;
    logic [WORD_W-1:0] ptr0, ptr1;
    logic [WORD_W-1:0] ram_rd;
    logic [WORD_W-1:0] cur_byte, new_byte, bit_mask;
    logic              do_write;
    logic              ram_we, ptr0_we, ptr1_we;

    assign op = acc_op_e'(op_i);

    dmem_decode #(
        .WORD_W   (WORD_W),
        .RAM_BASE (RAM_BASE),
        .WIN0_ADDR(WIN0_ADDR),
        .PTR0_ADDR(PTR0_ADDR),
        .WIN1_ADDR(WIN1_ADDR),
        .PTR1_ADDR(PTR1_ADDR),
        .TAP_MAP  (TAP_MAP)
    ) decode_i (
        .addr_i    (addr_i),
        .ptr0_i    (ptr0),
        .ptr1_i    (ptr1),
        .eff_addr_o(eff_addr),
        .cls_o     (cls)
    );

    dmem_ptr_regs #(.WORD_W(WORD_W)) ptrs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we0_i  (ptr0_we),
        .we1_i  (ptr1_we),
        .wdata_i(new_byte),
        .ptr0_o (ptr0),
        .ptr1_o (ptr1)
    );

    dmem_gp_ram #(.WORD_W(WORD_W), .RAM_BASE(RAM_BASE)) ram_i (
        .clk    (clk),
        .we_i   (ram_we),
        .addr_i (eff_addr),
        .wdata_i(new_byte),
        .rdata_o(ram_rd)
    );

    // Current byte of the resolved location, used for reads and read-modify-write
    always_comb begin
        case (cls)
            CLS_RAM:  cur_byte = ram_rd;
            CLS_PTR0: cur_byte = ptr0;
            CLS_PTR1: cur_byte = ptr1;
            CLS_TAP:  cur_byte = tap_rdata_i;
            default:  cur_byte = '0;
        endcase
    end

    always_comb begin
        bit_mask = WORD_W'(1) << bit_i;
        case (op)
            OP_WRITE: new_byte = wdata_i;
            OP_BSET:  new_byte = cur_byte | bit_mask;
            OP_BCLR:  new_byte = cur_byte & ~bit_mask;
            default:  new_byte = cur_byte;
        endcase
    end

    always_comb begin
        do_write = req_i && (op != OP_READ);
        ram_we   = do_write && (cls == CLS_RAM);
        ptr0_we  = do_write && (cls == CLS_PTR0);
        ptr1_we  = do_write && (cls == CLS_PTR1);
        st_d     = st_q;
        if (req_i && (op == OP_READ)) begin
            st_d.rdata = cur_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o     = st_q.rdata;
    assign tap_sel_o   = req_i && (cls == CLS_TAP);
    assign tap_we_o    = do_write && (cls == CLS_TAP);
    assign tap_addr_o  = eff_addr;
    assign tap_wdata_o = new_byte;

    // R6: the tap write strobe only names a tap location
    assert_tap_we_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tap_we_o |-> ((tap_addr_o < WORD_W'(RAM_BASE))
                      && TAP_MAP[tap_addr_o[TAP_IDX_W-1:0]]
                      && (tap_addr_o != WORD_W'(WIN0_ADDR))
                      && (tap_addr_o != WORD_W'(WIN1_ADDR))
                      && (tap_addr_o != WORD_W'(PTR0_ADDR))
                      && (tap_addr_o != WORD_W'(PTR1_ADDR))));
    // R8: at most one storage element written per cycle
    assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ptr0_we, ptr1_we, tap_we_o}));
    // R5: a read resolving to a window returns zero
    assert_null_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_i && (op == OP_READ) && (cls == CLS_NULL)))
        |-> (rdata_o == '0));
    // R3: a read of a reserved location returns zero
    assert_rsvd_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_i && (op == OP_READ) && (cls == CLS_RSVD)))
        |-> (rdata_o == '0));
    // R10: read data holds when no read is requested
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && (op == OP_READ)) |=> $stable(rdata_o));

endmodule

// File: tb/dmem_space_tb.sv
`timescale 1ns/1ps
module dmem_space_tb_top;

    localparam logic [1:0] OR_ = 2'd0;
    localparam logic [1:0] OW_ = 2'd1;
    localparam logic [1:0] OS_ = 2'd2;
    localparam logic [1:0] OC_ = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] addr;
        logic [7:0] wd;
        logic [2:0] bt;
        logic       chk;
        logic [7:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VECS [NV] = '{
        '{OW_, 8'h60, 8'h11, 3'd0, 1'b0, 8'h00, 4'd2},   // R2
        '{OR_, 8'h60, 8'h00, 3'd0, 1'b1, 8'h11, 4'd2},
        '{OW_, 8'hFF, 8'hEE, 3'd0, 1'b0, 8'h00, 4'd2},
        '{OR_, 8'hFF, 8'h00, 3'd0, 1'b1, 8'hEE, 4'd2},
        '{OW_, 8'h7F, 8'h5A, 3'd0, 1'b0, 8'h00, 4'd2},
        '{OR_, 8'h7F, 8'h00, 3'd0, 1'b1, 8'h5A, 4'd2},
        '{OW_, 8'h01, 8'h70, 3'd0, 1'b0, 8'h00, 4'd4},   // R4 window 0
        '{OW_, 8'h00, 8'h33, 3'd0, 1'b0, 8'h00, 4'd4},
        '{OR_, 8'h70, 8'h00, 3'd0, 1'b1, 8'h33, 4'd4},
        '{OR_, 8'h00, 8'h00, 3'd0, 1'b1, 8'h33, 4'd4},
        '{OW_, 8'h03, 8'h80, 3'd0, 1'b0, 8'h00, 4'd4},   // R4 window 1
        '{OW_, 8'h02, 8'hC4, 3'd0, 1'b0, 8'h00, 4'd4},
        '{OR_, 8'h80, 8'h00, 3'd0, 1'b1, 8'hC4, 4'd4},
        '{OR_, 8'h02, 8'h00, 3'd0, 1'b1, 8'hC4, 4'd4},
        '{OW_, 8'h30, 8'h99, 3'd0, 1'b0, 8'h00, 4'd3},   // R3 reserved
        '{OR_, 8'h30, 8'h00, 3'd0, 1'b1, 8'h00, 4'd3},
        '{OR_, 8'h08, 8'h00, 3'd0, 1'b1, 8'h00, 4'd3},
        '{OW_, 8'h05, 8'h3C, 3'd0, 1'b0, 8'h00, 4'd6},   // R6 accumulator tap
        '{OR_, 8'h05, 8'h00, 3'd0, 1'b1, 8'h3C, 4'd6},
        '{OS_, 8'h60, 8'h00, 3'd7, 1'b0, 8'h00, 4'd7},   // R7 set/clear RAM
        '{OR_, 8'h60, 8'h00, 3'd0, 1'b1, 8'h91, 4'd7},
        '{OC_, 8'h60, 8'h00, 3'd0, 1'b0, 8'h00, 4'd7},
        '{OR_, 8'h60, 8'h00, 3'd0, 1'b1, 8'h90, 4'd7},
        '{OS_, 8'h01, 8'h00, 3'd0, 1'b0, 8'h00, 4'd8},   // R8 bit on pointer
        '{OR_, 8'h01, 8'h00, 3'd0, 1'b1, 8'h71, 4'd8},
        '{OW_, 8'h71, 8'h0F, 3'd0, 1'b0, 8'h00, 4'd9},   // R9 bit through window
        '{OS_, 8'h00, 8'h00, 3'd4, 1'b0, 8'h00, 4'd9},
        '{OR_, 8'h71, 8'h00, 3'd0, 1'b1, 8'h1F, 4'd9},
        '{OC_, 8'h02, 8'h00, 3'd2, 1'b0, 8'h00, 4'd9},
        '{OR_, 8'h80, 8'h00, 3'd0, 1'b1, 8'hC0, 4'd9},
        '{OS_, 8'h05, 8'h00, 3'd0, 1'b0, 8'h00, 4'd8},   // R8 bit on tap
        '{OR_, 8'h05, 8'h00, 3'd0, 1'b1, 8'h3D, 4'd8},
        '{OW_, 8'h01, 8'h02, 3'd0, 1'b0, 8'h00, 4'd5},   // R5 null target
        '{OR_, 8'h00, 8'h00, 3'd0, 1'b1, 8'h00, 4'd5},
        '{OW_, 8'h00, 8'h55, 3'd0, 1'b0, 8'h00, 4'd5},
        '{OR_, 8'h01, 8'h00, 3'd0, 1'b1, 8'h02, 4'd5},
        '{OR_, 8'h03, 8'h00, 3'd0, 1'b1, 8'h80, 4'd5},
        '{OS_, 8'h00, 8'h00, 3'd1, 1'b0, 8'h00, 4'd5},
        '{OR_, 8'h01, 8'h00, 3'd0, 1'b1, 8'h02, 4'd5},
        '{OW_, 8'h03, 8'h00, 3'd0, 1'b0, 8'h00, 4'd5},
        '{OR_, 8'h02, 8'h00, 3'd0, 1'b1, 8'h00, 4'd5},
        '{OW_, 8'h02, 8'h77, 3'd0, 1'b0, 8'h00, 4'd5},
        '{OR_, 8'h03, 8'h00, 3'd0, 1'b1, 8'h00, 4'd5},
        '{OW_, 8'h01, 8'h03, 3'd0, 1'b0, 8'h00, 4'd4},   // R4 pointer names pointer
        '{OW_, 8'h00, 8'h90, 3'd0, 1'b0, 8'h00, 4'd4},
        '{OR_, 8'h03, 8'h00, 3'd0, 1'b1, 8'h90, 4'd4},
        '{OR_, 8'h00, 8'h00, 3'd0, 1'b1, 8'h90, 4'd4},
        '{OW_, 8'h01, 8'hFF, 3'd0, 1'b0, 8'h00, 4'd11},  // R11 next access
        '{OR_, 8'h00, 8'h00, 3'd0, 1'b1, 8'hEE, 4'd11}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [2:0] bt = 3'd0;
    logic [7:0] rdata;
    logic       tap_sel, tap_we;
    logic [7:0] tap_addr, tap_wdata, tap_rdata;
    logic [7:0] tap_mem [96];
    int         n_chk = 0;
    int         n_bad = 0;
    int         we_cnt = 0;

    always #2.5 clk = ~clk;

    dmem_space dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .op_i       (op),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .bit_i      (bt),
        .rdata_o    (rdata),
        .tap_sel_o  (tap_sel),
        .tap_we_o   (tap_we),
        .tap_addr_o (tap_addr),
        .tap_wdata_o(tap_wdata),
        .tap_rdata_i(tap_rdata)
    );

    // External special-register model
    assign tap_rdata = (tap_addr < 8'd96) ? tap_mem[tap_addr[6:0]] : 8'h00;

    always @(posedge clk) begin
        if (tap_we && tap_addr < 8'd96) begin
            tap_mem[tap_addr[6:0]] <= tap_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    task automatic check(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] o, input logic [7:0] a,
                         input logic [7:0] d, input logic [2:0] b);
        op = o; addr = a; wdata = d; bt = b; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        int snap;
        for (int i = 0; i < 96; i++) tap_mem[i] = 8'(i) ^ 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata after reset", rdata, 8'h00);
        do_op(OR_, 8'h01, 8'h00, 3'd0);
        check("R1 pointer 0", rdata, 8'h00);
        do_op(OR_, 8'h03, 8'h00, 3'd0);
        check("R1 pointer 1", rdata, 8'h00);

        for (int v = 0; v < NV; v++) begin
            do_op(VECS[v].op, VECS[v].addr, VECS[v].wd, VECS[v].bt);
            if (VECS[v].chk) begin
                check($sformatf("R%0d vector %0d", VECS[v].rq, v), rdata, VECS[v].exp);
            end
        end

        // R10 read data holds over write, bit op and idle
        do_op(OR_, 8'h60, 8'h00, 3'd0);
        check("R10 read", rdata, 8'h90);
        do_op(OW_, 8'h61, 8'h42, 3'd0);
        check("R10 hold over write", rdata, 8'h90);
        do_op(OS_, 8'h61, 8'h00, 3'd0);
        @(negedge clk);
        check("R10 hold over bit op and idle", rdata, 8'h90);

        // R6 tap strobe and tap read of an untouched location
        snap = we_cnt;
        do_op(OW_, 8'h0A, 8'hAB, 3'd0);
        check("R6 strobe count", 8'(we_cnt - snap), 8'h01);
        check("R6 tap stored", tap_mem[8'h0A], 8'hAB);
        do_op(OR_, 8'h12, 8'h00, 3'd0);
        check("R6 tap read", rdata, 8'h12 ^ 8'hA5);

        // R3 reserved write and bit op raise no strobe
        snap = we_cnt;
        do_op(OW_, 8'h31, 8'h44, 3'd0);
        do_op(OS_, 8'h09, 8'h00, 3'd3);
        check("R3 no strobe", 8'(we_cnt - snap), 8'h00);
        do_op(OR_, 8'h09, 8'h00, 3'd0);
        check("R3 reserved bit op read", rdata, 8'h00);

        // R1 reset in mid-run clears pointers
        do_op(OW_, 8'h01, 8'h55, 3'd0);
        do_op(OW_, 8'h03, 8'h66, 3'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after second reset", rdata, 8'h00);
        do_op(OR_, 8'h01, 8'h00, 3'd0);
        check("R1 pointer 0 after second reset", rdata, 8'h00);
        do_op(OR_, 8'h03, 8'h00, 3'd0);
        check("R1 pointer 1 after second reset", rdata, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule